// File: doc/BRIEF.md
# Receive Buffer with Line Status

This block sits between a UART's serial receiver and the CPU bus. Every character the receiver finishes is written into a queue together with three error tags: break, framing and parity. The CPU sees an 8-bit line status word. That word shows whether data is waiting, the error tags of the oldest unread character, a sticky overrun indication, a summary of whether any queued character is tagged, and two transmitter-idle flags.

A framing error means the stop bit was not valid. A parity error means the received parity did not match the configured odd or even setting. The receiver's break detector raises a separate one-cycle strobe when the line has stayed low for a whole character frame. That strobe queues exactly one zero byte tagged as break.

The CPU has two separate read strobes. A status read only samples the status word and clears the overrun flag. A buffer read removes the oldest entry. The status word and the oldest byte are presented combinationally from registered state. The transmitter flags are registered once before they reach the status word.

Top module: `rxq_top`

## Requirements
- R1: After reset the status word is 0x60 (only bits 6 and 5 set) and the buffer data output is 0x00.
- R2: Status bit 0 is 1 exactly when at least one character is queued, from the cycle after the push that makes the queue non-empty.
- R3: A status read never removes an entry. Only a buffer read with a non-empty queue advances the head.
- R4: Status bits 4, 3 and 2 show the break, framing and parity tags of the oldest queued character, in that order. When the queue is empty they read 0.
- R5: Status bit 7 is 1 while any queued character has at least one tag set, and 0 once none remains.
- R6: A character that arrives when the queue holds DEPTH entries and no buffer read happens in that cycle is dropped, and stored entries are unchanged. Status bit 1 is then set, and it stays set until a status read clears it; a new overrun in that same cycle wins. An arrival into a full queue in the same cycle as a buffer read is stored, and no overrun is raised.
- R7: A break strobe queues one entry with data 0x00 and only the break tag set. If a character strobe arrives in the same cycle, that character is discarded.
- R8: Status bit 5 equals the transmit-holding-empty input and bit 6 equals the AND of holding-empty and shift-empty, each delayed by one clock.
- R9: A push and a buffer read in the same cycle on a non-empty queue keep the occupancy the same. The tag summary accounts for both the added and the removed character.
- R10: A buffer read on an empty queue has no effect. The data output is 0x00 while the queue is empty.
- R11: Characters leave in arrival order, and the queue holds up to DEPTH (default 256) entries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| charValid | input | 1 | One-cycle strobe: a received character is ready |
| charData | input | 8 | Received byte |
| charBrk | input | 1 | Break tag of the received byte |
| charFrm | input | 1 | Framing-error tag of the received byte |
| charPar | input | 1 | Parity-error tag of the received byte |
| brkDetect | input | 1 | One-cycle strobe: break condition detected |
| txHoldEmpty | input | 1 | Transmit holding register is empty |
| txShiftEmpty | input | 1 | Transmit shift register is empty |
| statusRead | input | 1 | CPU reads the line status word |
| bufferRead | input | 1 | CPU reads the receive buffer (pops the head) |
| statusOut | output | 8 | Line status word |
| bufferData | output | 8 | Byte at the head of the queue |

## Verification
The assertions assume that the receiver strobes last one cycle per character and that each CPU read strobe is one cycle per access. They also assume DEPTH is a power of two, so the pointers wrap without compare logic. The bench drives every input on the falling edge for one cycle per operation and never issues a character strobe and a break strobe together, except in the one directed case that tests their priority. Full-queue behaviour is reached by writing exactly DEPTH characters before any read, which keeps the occupancy within the range the bound checks expect.

// File: rtl/rxq_pkg.sv
package rxq_pkg;
  localparam int DATA_W = 8;
  localparam int STAT_W = 8;

  // Status word bit positions
  localparam int ST_READY   = 0;
  localparam int ST_OVERRUN = 1;
  localparam int ST_PAR     = 2;
  localparam int ST_FRM     = 3;
  localparam int ST_BRK     = 4;
  localparam int ST_THOLD   = 5;
  localparam int ST_TIDLE   = 6;
  localparam int ST_ANYERR  = 7;

  typedef struct packed {
    logic              brk;
    logic              frm;
    logic              par;
    logic [DATA_W-1:0] data;
  } rxEntry_t;

  typedef struct packed {
    logic     push;
    logic     pop;
    rxEntry_t wrEntry;
  } storeCmd_t;

  function automatic logic isTagged(rxEntry_t e);
    return e.brk | e.frm | e.par;
  endfunction
endpackage

// File: rtl/rxq_store.sv
module rxq_store
  import rxq_pkg::*;
#(
  parameter int DEPTH = 256
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  storeCmd_t                    cmd,
  output rxEntry_t                     headEntry,
  output logic [$clog2(DEPTH+1)-1:0]   level,
  output logic                         full,
  output logic                         empty
);
  localparam int PTR_W = $clog2(DEPTH);
  localparam int LVL_W = $clog2(DEPTH + 1);

  generate
    if ((DEPTH & (DEPTH - 1)) != 0 || DEPTH < 2) begin : g_badDepth
      $error("rxq_store: DEPTH must be a power of two, at least 2");
    end
  endgenerate

  rxEntry_t          mem [DEPTH];
  logic [PTR_W-1:0]  wrPtr, rdPtr;
  logic [LVL_W-1:0]  levelQ;

  always_ff @(posedge clk) begin
    if (cmd.push) mem[wrPtr] <= cmd.wrEntry;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr  <= '0;
      rdPtr  <= '0;
      levelQ <= '0;
    end else begin
      if (cmd.push) wrPtr <= wrPtr + 1'b1;
      if (cmd.pop)  rdPtr <= rdPtr + 1'b1;
      unique case ({cmd.push, cmd.pop})
        2'b10:   levelQ <= levelQ + 1'b1;
        2'b01:   levelQ <= levelQ - 1'b1;
        default: levelQ <= levelQ;
      endcase
    end
  end

  assign level     = levelQ;
  assign empty     = (levelQ == '0);
  assign full      = (levelQ == LVL_W'(DEPTH));
  assign headEntry = empty ? '0 : mem[rdPtr];

  a_r11_level_bound: assert property (@(posedge clk) disable iff (!rstN)
    levelQ <= LVL_W'(DEPTH));
  a_r10_no_pop_when_empty: assert property (@(posedge clk) disable iff (!rstN)
    cmd.pop |-> !empty);
  a_r3_head_moves_only_on_pop: assert property (@(posedge clk) disable iff (!rstN)
    !cmd.pop |=> $stable(rdPtr));
  a_r6_no_push_when_full: assert property (@(posedge clk) disable iff (!rstN)
    (full && !cmd.pop) |-> !cmd.push);
endmodule

// File: rtl/rxq_ctrl.sv
module rxq_ctrl
  import rxq_pkg::*;
#(
  parameter int DEPTH = 256
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic                         charValid,
  input  logic [DATA_W-1:0]            charData,
  input  logic                         charBrk,
  input  logic                         charFrm,
  input  logic                         charPar,
  input  logic                         brkDetect,
  input  logic                         txHoldEmpty,
  input  logic                         txShiftEmpty,
  input  logic                         statusRead,
  input  logic                         bufferRead,
  input  rxEntry_t                     headEntry,
  input  logic [$clog2(DEPTH+1)-1:0]   level,
  input  logic                         full,
  input  logic                         empty,
  output storeCmd_t                    cmd,
  output logic [STAT_W-1:0]            statusOut,
  output logic [DATA_W-1:0]            bufferData
);
  localparam int LVL_W = $clog2(DEPTH + 1);

  logic             pushReq, pushOk, popOk, overrunSet;
  logic             incTag, decTag;
  rxEntry_t         newEntry;
  logic [LVL_W-1:0] tagCount;
  logic             overrunQ, holdQ, idleQ;

  // Break strobe takes priority over a character strobe
  always_comb begin
    if (brkDetect) begin
      newEntry      = '0;
      newEntry.brk  = 1'b1;
    end else begin
      newEntry.brk  = charBrk;
      newEntry.frm  = charFrm;
      newEntry.par  = charPar;
      newEntry.data = charData;
    end
  end

  assign pushReq    = charValid | brkDetect;
  assign popOk      = bufferRead & ~empty;
  assign pushOk     = pushReq & (~full | popOk);
  assign overrunSet = pushReq & full & ~popOk;
  assign incTag     = pushOk & isTagged(newEntry);
  assign decTag     = popOk & isTagged(headEntry);

  assign cmd.push    = pushOk;
  assign cmd.pop     = popOk;
  assign cmd.wrEntry = newEntry;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tagCount <= '0;
      overrunQ <= 1'b0;
      holdQ    <= 1'b1;
      idleQ    <= 1'b1;
    end else begin
      unique case ({incTag, decTag})
        2'b10:   tagCount <= tagCount + 1'b1;
        2'b01:   tagCount <= tagCount - 1'b1;
        default: tagCount <= tagCount;
      endcase
      if (overrunSet)      overrunQ <= 1'b1;
      else if (statusRead) overrunQ <= 1'b0;
      holdQ <= txHoldEmpty;
      idleQ <= txHoldEmpty & txShiftEmpty;
    end
  end

  always_comb begin
    statusOut             = '0;
    statusOut[ST_READY]   = ~empty;
    statusOut[ST_OVERRUN] = overrunQ;
    statusOut[ST_PAR]     = headEntry.par;
    statusOut[ST_FRM]     = headEntry.frm;
    statusOut[ST_BRK]     = headEntry.brk;
    statusOut[ST_THOLD]   = holdQ;
    statusOut[ST_TIDLE]   = idleQ;
    statusOut[ST_ANYERR]  = (tagCount != '0);
  end

  assign bufferData = headEntry.data;

  a_r6_overrun_raised: assert property (@(posedge clk) disable iff (!rstN)
    (pushReq && full && !bufferRead) |=> statusOut[ST_OVERRUN]);
  a_r5_tags_within_level: assert property (@(posedge clk) disable iff (!rstN)
    tagCount <= level);
  a_r4_empty_shows_no_tags: assert property (@(posedge clk) disable iff (!rstN)
    empty |-> (statusOut[ST_BRK:ST_PAR] == 3'b000));
  a_r2_ready_from_push: assert property (@(posedge clk) disable iff (!rstN)
    $rose(statusOut[ST_READY]) |-> $past(cmd.push));
  a_r8_idle_implies_hold: assert property (@(posedge clk) disable iff (!rstN)
    statusOut[ST_TIDLE] |-> statusOut[ST_THOLD]);
  a_r3_status_read_keeps_level: assert property (@(posedge clk) disable iff (!rstN)
    (statusRead && !bufferRead && !pushReq) |=> $stable(level));
endmodule

// File: rtl/rxq_top.sv
module rxq_top
  import rxq_pkg::*;
#(
  parameter int DEPTH = 256
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        charValid,
  input  logic [7:0]  charData,
  input  logic        charBrk,
  input  logic        charFrm,
  input  logic        charPar,
  input  logic        brkDetect,
  input  logic        txHoldEmpty,
  input  logic        txShiftEmpty,
  input  logic        statusRead,
  input  logic        bufferRead,
  output logic [7:0]  statusOut,
  output logic [7:0]  bufferData
);
  localparam int LVL_W = $clog2(DEPTH + 1);

  storeCmd_t        cmd;
  rxEntry_t         headEntry;
  logic [LVL_W-1:0] level;
  logic             full, empty;

  rxq_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk(clk), .rstN(rstN),
    .charValid(charValid), .charData(charData),
    .charBrk(charBrk), .charFrm(charFrm), .charPar(charPar),
    .brkDetect(brkDetect),
    .txHoldEmpty(txHoldEmpty), .txShiftEmpty(txShiftEmpty),
    .statusRead(statusRead), .bufferRead(bufferRead),
    .headEntry(headEntry), .level(level), .full(full), .empty(empty),
    .cmd(cmd), .statusOut(statusOut), .bufferData(bufferData)
  );

  rxq_store #(.DEPTH(DEPTH)) u_store (
    .clk(clk), .rstN(rstN), .cmd(cmd),
    .headEntry(headEntry), .level(level), .full(full), .empty(empty)
  );
endmodule

// File: tb/rxq_top_bench.sv
module rxq_top_bench;
  localparam int DEPTH = 256;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic charValid = 0, charBrk = 0, charFrm = 0, charPar = 0, brkDetect = 0;
  logic [7:0] charData = '0;
  logic txHoldEmpty = 1, txShiftEmpty = 1, statusRead = 0, bufferRead = 0;
  logic [7:0] statusOut, bufferData;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 0;

  always #2 clk = ~clk;

  rxq_top #(.DEPTH(DEPTH)) u_rxq_top (
    .clk(clk), .rstN(rstN), .charValid(charValid), .charData(charData),
    .charBrk(charBrk), .charFrm(charFrm), .charPar(charPar),
    .brkDetect(brkDetect), .txHoldEmpty(txHoldEmpty), .txShiftEmpty(txShiftEmpty),
    .statusRead(statusRead), .bufferRead(bufferRead),
    .statusOut(statusOut), .bufferData(bufferData)
  );

  typedef struct packed {
    logic       push;
    logic [7:0] d;
    logic [2:0] tag;   // {brk, frm, par}
    logic       pop;
    logic       stat;
    logic [7:0] expStat;
    logic [7:0] expData;
  } vec_t;

  localparam vec_t VECS [11] = '{
    '{1'b1, 8'h11, 3'b000, 1'b0, 1'b0, 8'h61, 8'h11},  // R2 R11
    '{1'b1, 8'h22, 3'b001, 1'b0, 1'b0, 8'hE1, 8'h11},  // R5 R4 head clean
    '{1'b1, 8'h33, 3'b010, 1'b0, 1'b0, 8'hE1, 8'h11},
    '{1'b0, 8'h00, 3'b000, 1'b1, 1'b0, 8'hE5, 8'h22},  // R4 parity head
    '{1'b0, 8'h00, 3'b000, 1'b0, 1'b1, 8'hE5, 8'h22},  // R3 status read
    '{1'b0, 8'h00, 3'b000, 1'b1, 1'b0, 8'hE9, 8'h33},  // R4 framing head
    '{1'b1, 8'h44, 3'b000, 1'b1, 1'b0, 8'h61, 8'h44},  // R9
    '{1'b0, 8'h00, 3'b000, 1'b1, 1'b0, 8'h60, 8'h00},  // R2 empty
    '{1'b0, 8'h00, 3'b000, 1'b1, 1'b0, 8'h60, 8'h00},  // R10
    '{1'b1, 8'h55, 3'b110, 1'b0, 1'b0, 8'hF9, 8'h55},  // R4 brk+frm
    '{1'b0, 8'h00, 3'b000, 1'b1, 1'b0, 8'h60, 8'h00}   // R5 cleared
  };

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
    end
  endtask

  // Drive one cycle of stimulus; return on the following falling edge
  task automatic step(logic push, logic [7:0] d, logic [2:0] tag, logic pop, logic stat);
    charValid  = push;
    charData   = d;
    {charBrk, charFrm, charPar} = tag;
    bufferRead = pop;
    statusRead = stat;
    @(posedge clk);
    @(negedge clk);
    charValid = 0; bufferRead = 0; statusRead = 0;
    {charBrk, charFrm, charPar} = 3'b000;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 status", statusOut, 8'h60);
    check("R1 data", bufferData, 8'h00);
    rstN = 1'b1;
    @(negedge clk);

    foreach (VECS[i]) begin
      step(VECS[i].push, VECS[i].d, VECS[i].tag, VECS[i].pop, VECS[i].stat);
      check($sformatf("vector %0d status", i), statusOut, VECS[i].expStat);
      check($sformatf("vector %0d data", i), bufferData, VECS[i].expData);
    end

    // R7: break strobe beats a simultaneous character
    brkDetect = 1;
    step(1'b1, 8'h77, 3'b000, 1'b0, 1'b0);
    brkDetect = 0;
    check("R7 break status", statusOut, 8'hF1);
    check("R7 break data", bufferData, 8'h00);
    step(1'b0, 8'h00, 3'b000, 1'b1, 1'b0);
    check("R7 single entry", statusOut, 8'h60);

    // R8: transmitter flags, one clock late
    txHoldEmpty = 0;
    #1 check("R8 before edge", statusOut, 8'h60);
    step(1'b0, 8'h00, 3'b000, 1'b0, 1'b0);
    check("R8 hold busy", statusOut, 8'h00);
    txHoldEmpty = 1; txShiftEmpty = 0;
    step(1'b0, 8'h00, 3'b000, 1'b0, 1'b0);
    check("R8 shift busy", statusOut, 8'h20);
    txShiftEmpty = 1;
    step(1'b0, 8'h00, 3'b000, 1'b0, 1'b0);
    check("R8 both idle", statusOut, 8'h60);

    // R11 / R6: fill to DEPTH
    for (int i = 0; i < DEPTH; i++) step(1'b1, 8'(i), 3'b000, 1'b0, 1'b0);
    check("R11 full status", statusOut, 8'h61);
    check("R11 full head", bufferData, 8'h00);
    step(1'b1, 8'hAB, 3'b000, 1'b1, 1'b0);
    check("R6 push+pop when full, no overrun", statusOut, 8'h61);
    check("R6 push+pop head", bufferData, 8'h01);
    step(1'b1, 8'hEE, 3'b000, 1'b0, 1'b0);
    check("R6 overrun set", statusOut, 8'h63);
    check("R6 head untouched", bufferData, 8'h01);
    step(1'b0, 8'h00, 3'b000, 1'b0, 1'b1);
    check("R6 overrun cleared by status read", statusOut, 8'h61);

    for (int i = 1; i <= DEPTH; i++) begin
      check($sformatf("R11 order %0d", i), bufferData, (i == DEPTH) ? 8'hAB : 8'(i));
      step(1'b0, 8'h00, 3'b000, 1'b1, 1'b0);
    end
    check("R6 dropped byte absent", statusOut, 8'h60);
    check("R10 empty data", bufferData, 8'h00);
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        nChecks++;
        nFails++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule